// File: doc/BRIEF.md
# Partial-Tag Snoop Filter

This block sits between the private data caches of a multi-core cluster and the snooping bus. For every line held in every core's set-associative data cache, it keeps a short copy of the line's low-order tag bits, a valid flag and a dirty flag. When a core misses in its own cache, it presents the miss address here before anything goes on the bus. The block reads the indexed set for every other core and compares the short tag against each valid copy.

If no other core has a matching copy, the line cannot be in any peer cache. The request may then go straight to the upper-level cache, with no snoop. If some copies match, the block names only those cores as snoop targets. A match on a few tag bits can still be a false positive, so a named core may turn out not to hold the line. A second mask marks the targets whose matching copy is dirty. The result is registered and is due one cycle after the lookup.

The copies are kept current by fill notices (core, way, address, dirty flag) and by invalidate notices (core, set, way) that come from the caches.

Top module: `ptag_snoop_filter`

## Requirements
- R1: After reset, every entry is invalid and `res_valid`, `res_no_snoop`, `res_targets` and `res_dirty` are all 0. A lookup made before any fill reports `res_no_snoop`=1 with an empty target mask.
- R2: The set index is `addr[OFF_W+SET_W-1:OFF_W]`. The partial tag is the next `PTAG_W` bits, `addr[OFF_W+SET_W+PTAG_W-1:OFF_W+SET_W]` (with defaults: set = addr[9:6], partial tag = addr[17:10]).
- R3: A fill with `fill_valid`=1 makes the entry at (`fill_core`, set of `fill_addr`, `fill_way`) valid. It stores that address's partial tag and `fill_dirty`.
- R4: `res_valid` is 1 exactly in the cycle after a cycle with `lk_valid`=1. When `res_valid` is 0, all other result outputs are 0.
- R5: If no valid entry of a non-requesting core, in the indexed set, holds the request's partial tag, the result has `res_no_snoop`=1 and `res_targets`=0.
- R6: Bit c of `res_targets` is 1 when a valid entry of core c in the indexed set holds the request's partial tag. Tag bits above the partial tag are not compared, so they do not affect the result. In that case `res_no_snoop`=0.
- R7: The requesting core's own entries never contribute, so bit `lk_core` of `res_targets` is always 0.
- R8: An invalidate with `inv_valid`=1 clears the valid flag of the entry at (`inv_core`, `inv_set`, `inv_way`). All other entries are unchanged.
- R9: Bit c of `res_dirty` is 1 when a matching entry of core c has its dirty flag set. `res_dirty` is always a subset of `res_targets`.
- R10: A lookup in the same cycle as a fill or an invalidate sees the entries as they were before that update.
- R11: If a fill and an invalidate name the same entry in the same cycle, the fill takes effect.
- R12: Entries in other sets never match a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request for a local miss |
| lk_core | input | CORE_W | Requesting core |
| lk_addr | input | ADDR_W | Miss address |
| fill_valid | input | 1 | Line placed in a cache |
| fill_core | input | CORE_W | Core that filled |
| fill_way | input | WAY_W | Way filled |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_dirty | input | 1 | Dirty state of the filled line |
| inv_valid | input | 1 | Line removed from a cache |
| inv_core | input | CORE_W | Core losing the line |
| inv_set | input | SET_W | Set of the removed line |
| inv_way | input | WAY_W | Way of the removed line |
| res_valid | output | 1 | Result qualifier |
| res_no_snoop | output | 1 | No peer can hold the line; go to the upper level |
| res_targets | output | NUM_CORES | Cores to snoop |
| res_dirty | output | NUM_CORES | Targets whose matching copy is dirty |

## Verification
A lookup result appears after exactly one register stage. The bench drives each request on a falling edge and compares all four result outputs on the next falling edge, half a cycle after the edge that registers them. It computes the expected values from its own model of the entries, taken before that cycle's fill and invalidate are applied to the model. A fill or invalidate becomes visible to a lookup issued on the following cycle, so lookups used to observe an update are always issued one cycle later.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

   // Update applied to one filter entry in a cycle; fill outranks invalidate.
   typedef enum logic [1:0] {
      UPD_NONE = 2'd0,
      UPD_INV  = 2'd1,
      UPD_FILL = 2'd2
   } ptf_upd_e;

   // Default geometry of the cluster.
   localparam int unsigned DEF_CORES  = 4;
   localparam int unsigned DEF_WAYS   = 4;
   localparam int unsigned DEF_SETS   = 16;
   localparam int unsigned DEF_PTAG_W = 8;

endpackage

// File: rtl/ptf_core_store.sv
module ptf_core_store
   import ptf_pkg::*;
#(
   parameter int unsigned NUM_SETS = DEF_SETS,
   parameter int unsigned NUM_WAYS = DEF_WAYS,
   parameter int unsigned PTAG_W   = DEF_PTAG_W,
   localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
   localparam int unsigned WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fill_en,
   input  logic [SET_W-1:0]           fill_set,
   input  logic [WAY_W-1:0]           fill_way,
   input  logic [PTAG_W-1:0]          fill_ptag,
   input  logic                       fill_dirty,
   input  logic                       inv_en,
   input  logic [SET_W-1:0]           inv_set,
   input  logic [WAY_W-1:0]           inv_way,
   input  logic [SET_W-1:0]           rd_set,
   output logic [NUM_WAYS-1:0]        rd_valid,
   output logic [NUM_WAYS*PTAG_W-1:0] rd_ptag,
   output logic [NUM_WAYS-1:0]        rd_dirty
);

   logic [NUM_WAYS-1:0] vld_q [NUM_SETS];
   logic [NUM_WAYS-1:0] drt_q [NUM_SETS];
   logic [PTAG_W-1:0]   tag_q [NUM_SETS][NUM_WAYS];

   ptf_upd_e upd [NUM_SETS][NUM_WAYS];

   always_comb begin
      for (int s = 0; s < NUM_SETS; s++) begin
         for (int w = 0; w < NUM_WAYS; w++) begin
            if (fill_en && fill_set == SET_W'(s) && fill_way == WAY_W'(w))
               upd[s][w] = UPD_FILL;
            else if (inv_en && inv_set == SET_W'(s) && inv_way == WAY_W'(w))
               upd[s][w] = UPD_INV;
            else
               upd[s][w] = UPD_NONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            vld_q[s] <= '0;
            drt_q[s] <= '0;
            for (int w = 0; w < NUM_WAYS; w++) tag_q[s][w] <= '0;
         end
      end else begin
         for (int s = 0; s < NUM_SETS; s++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
               case (upd[s][w])
                  UPD_FILL: begin
                     vld_q[s][w] <= 1'b1;
                     drt_q[s][w] <= fill_dirty;
                     tag_q[s][w] <= fill_ptag;
                  end
                  UPD_INV:  vld_q[s][w] <= 1'b0;
                  default:  ;
               endcase
            end
         end
      end
   end

   // Read port returns the registered contents, so a same-cycle update is not seen.
   assign rd_valid = vld_q[rd_set];
   assign rd_dirty = drt_q[rd_set];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
      assign rd_ptag[w*PTAG_W +: PTAG_W] = tag_q[rd_set][w];
   end

endmodule

// File: rtl/ptf_way_match.sv
module ptf_way_match
   import ptf_pkg::*;
#(
   parameter int unsigned NUM_WAYS = DEF_WAYS,
   parameter int unsigned PTAG_W   = DEF_PTAG_W
) (
   input  logic [NUM_WAYS-1:0]        ent_valid,
   input  logic [NUM_WAYS*PTAG_W-1:0] ent_ptag,
   input  logic [NUM_WAYS-1:0]        ent_dirty,
   input  logic [PTAG_W-1:0]          key,
   output logic                       hit,
   output logic                       dirty_hit
);

   logic [NUM_WAYS-1:0] way_hit;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign way_hit[w] = ent_valid[w] && (ent_ptag[w*PTAG_W +: PTAG_W] == key);
   end

   assign hit       = |way_hit;
   assign dirty_hit = |(way_hit & ent_dirty);

endmodule

// File: rtl/ptag_snoop_filter.sv
module ptag_snoop_filter
   import ptf_pkg::*;
#(
   parameter int unsigned NUM_CORES = DEF_CORES,
   parameter int unsigned NUM_WAYS  = DEF_WAYS,
   parameter int unsigned NUM_SETS  = DEF_SETS,
   parameter int unsigned PTAG_W    = DEF_PTAG_W,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned OFF_W     = 6,
   localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int unsigned WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
   localparam int unsigned SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lk_valid,
   input  logic [CORE_W-1:0]    lk_core,
   input  logic [ADDR_W-1:0]    lk_addr,
   input  logic                 fill_valid,
   input  logic [CORE_W-1:0]    fill_core,
   input  logic [WAY_W-1:0]     fill_way,
   input  logic [ADDR_W-1:0]    fill_addr,
   input  logic                 fill_dirty,
   input  logic                 inv_valid,
   input  logic [CORE_W-1:0]    inv_core,
   input  logic [SET_W-1:0]     inv_set,
   input  logic [WAY_W-1:0]     inv_way,
   output logic                 res_valid,
   output logic                 res_no_snoop,
   output logic [NUM_CORES-1:0] res_targets,
   output logic [NUM_CORES-1:0] res_dirty
);

   localparam int unsigned SET_LSB  = OFF_W;
   localparam int unsigned PTAG_LSB = OFF_W + SET_W;

   // Elaboration-time parameter checks.
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("ptag_snoop_filter: NUM_CORES must be at least 2");
   end
   if ((1 << SET_W) != NUM_SETS) begin : g_bad_sets
      $error("ptag_snoop_filter: NUM_SETS must be a power of two");
   end
   if ((1 << WAY_W) != NUM_WAYS) begin : g_bad_ways
      $error("ptag_snoop_filter: NUM_WAYS must be a power of two");
   end
   if (PTAG_LSB + PTAG_W > ADDR_W) begin : g_bad_addr
      $error("ptag_snoop_filter: address too narrow for offset, index and partial tag");
   end

   // Address split shared by lookup and fill.
   logic [SET_W-1:0]  lk_set, fill_set;
   logic [PTAG_W-1:0] lk_ptag, fill_ptag;

   assign lk_set    = lk_addr[SET_LSB +: SET_W];
   assign lk_ptag   = lk_addr[PTAG_LSB +: PTAG_W];
   assign fill_set  = fill_addr[SET_LSB +: SET_W];
   assign fill_ptag = fill_addr[PTAG_LSB +: PTAG_W];

   logic [NUM_CORES-1:0] core_hit;
   logic [NUM_CORES-1:0] core_dirty_hit;
   logic [NUM_CORES-1:0] peer_mask;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic                       fill_sel, inv_sel;
      logic [NUM_WAYS-1:0]        rd_valid, rd_dirty;
      logic [NUM_WAYS*PTAG_W-1:0] rd_ptag;

      assign fill_sel     = fill_valid && (fill_core == CORE_W'(c));
      assign inv_sel      = inv_valid  && (inv_core  == CORE_W'(c));
      assign peer_mask[c] = (lk_core != CORE_W'(c));

      ptf_core_store #(
         .NUM_SETS (NUM_SETS),
         .NUM_WAYS (NUM_WAYS),
         .PTAG_W   (PTAG_W)
      ) u_store (
         .clk        (clk),
         .rst_n      (rst_n),
         .fill_en    (fill_sel),
         .fill_set   (fill_set),
         .fill_way   (fill_way),
         .fill_ptag  (fill_ptag),
         .fill_dirty (fill_dirty),
         .inv_en     (inv_sel),
         .inv_set    (inv_set),
         .inv_way    (inv_way),
         .rd_set     (lk_set),
         .rd_valid   (rd_valid),
         .rd_ptag    (rd_ptag),
         .rd_dirty   (rd_dirty)
      );

      ptf_way_match #(
         .NUM_WAYS (NUM_WAYS),
         .PTAG_W   (PTAG_W)
      ) u_match (
         .ent_valid (rd_valid),
         .ent_ptag  (rd_ptag),
         .ent_dirty (rd_dirty),
         .key       (lk_ptag),
         .hit       (core_hit[c]),
         .dirty_hit (core_dirty_hit[c])
      );
   end

   logic [NUM_CORES-1:0] tgt_d, drt_d;

   assign tgt_d = lk_valid ? (core_hit & peer_mask) : '0;
   assign drt_d = lk_valid ? (core_dirty_hit & peer_mask) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_no_snoop <= 1'b0;
         res_targets  <= '0;
         res_dirty    <= '0;
      end else begin
         res_valid    <= lk_valid;
         res_no_snoop <= lk_valid && (tgt_d == '0);
         res_targets  <= tgt_d;
         res_dirty    <= drt_d;
      end
   end

endmodule

// File: rtl/ptf_chk.sv
module ptf_chk #(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned CORE_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 lk_valid,
   input logic [CORE_W-1:0]    lk_core,
   input logic                 res_valid,
   input logic                 res_no_snoop,
   input logic [NUM_CORES-1:0] res_targets,
   input logic [NUM_CORES-1:0] res_dirty
);

   AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid); // R4

   AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid); // R4

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_no_snoop && res_targets == '0 && res_dirty == '0)); // R4

   AST_SKIP_HAS_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_no_snoop) |-> (res_targets == '0)); // R5

   AST_TARGET_BLOCKS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_targets != '0) |-> !res_no_snoop); // R6

   AST_SELF_NOT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid ##1 res_valid) |-> !res_targets[$past(lk_core)]); // R7

   AST_DIRTY_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (res_dirty & ~res_targets) == '0); // R9

endmodule

bind ptag_snoop_filter ptf_chk #(
   .NUM_CORES (NUM_CORES),
   .CORE_W    (CORE_W)
) u_ptf_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_valid     (lk_valid),
   .lk_core      (lk_core),
   .res_valid    (res_valid),
   .res_no_snoop (res_no_snoop),
   .res_targets  (res_targets),
   .res_dirty    (res_dirty)
);

// File: tb/tb_ptag_snoop_filter.sv
`timescale 1ns/1ps
module tb_ptag_snoop_filter;

   localparam int NC = 4, NW = 4, NS = 16, PW = 8, AW = 32, OW = 6, SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 0, fill_valid = 0, fill_dirty = 0, inv_valid = 0;
   logic [1:0]    lk_core = 0, fill_core = 0, fill_way = 0, inv_core = 0, inv_way = 0;
   logic [3:0]    inv_set = 0;
   logic [31:0]   lk_addr = 0, fill_addr = 0;
   logic          res_valid, res_no_snoop;
   logic [NC-1:0] res_targets, res_dirty;

   always #2.5 clk = ~clk;

   ptag_snoop_filter dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_core(lk_core), .lk_addr(lk_addr),
      .fill_valid(fill_valid), .fill_core(fill_core), .fill_way(fill_way),
      .fill_addr(fill_addr), .fill_dirty(fill_dirty),
      .inv_valid(inv_valid), .inv_core(inv_core), .inv_set(inv_set), .inv_way(inv_way),
      .res_valid(res_valid), .res_no_snoop(res_no_snoop),
      .res_targets(res_targets), .res_dirty(res_dirty)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   // Bench model of the entries.
   bit          mv [NC][NS][NW];
   bit          md [NC][NS][NW];
   logic [7:0]  mt [NC][NS][NW];

   // R2: set at addr[9:6], partial tag at addr[17:10].
   function automatic logic [31:0] mk(input int ptag, input int set, input int upper);
      return {upper[13:0], ptag[7:0], set[3:0], 6'h15};
   endfunction

   function automatic int pt(input int c, input int s, input int w);
      return (c*37 + s*11 + w*5) % 251;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One cycle: drive at a falling edge, check the registered result at the next one.
   task automatic cyc(input bit lv, input int lc, input logic [31:0] la,
                      input bit fv, input int fc, input int fw, input logic [31:0] fa, input bit fd,
                      input bit iv, input int ic, input int iset, input int iw, input string ph);
      logic [NC-1:0] et, ed;
      int s;
      lk_valid = lv; lk_core = lc[1:0]; lk_addr = la;
      fill_valid = fv; fill_core = fc[1:0]; fill_way = fw[1:0]; fill_addr = fa; fill_dirty = fd;
      inv_valid = iv; inv_core = ic[1:0]; inv_set = iset[3:0]; inv_way = iw[1:0];
      et = '0; ed = '0;
      if (lv) begin
         s = int'(la[9:6]);
         for (int c = 0; c < NC; c++)
            if (c != lc)
               for (int w = 0; w < NW; w++)
                  if (mv[c][s][w] && mt[c][s][w] == la[17:10]) begin
                     et[c] = 1'b1;
                     if (md[c][s][w]) ed[c] = 1'b1;
                  end
      end
      // Model update after the lookup (R10); fill applied last so it wins (R11).
      if (iv) mv[ic][iset][iw] = 1'b0;
      if (fv) begin
         s = int'(fa[9:6]);
         mv[fc][s][fw] = 1'b1;
         mt[fc][s][fw] = fa[17:10];
         md[fc][s][fw] = fd;
      end
      @(negedge clk);
      chk(res_valid == lv, "R4", {ph, " res_valid"}, res_valid, lv);
      chk(res_targets == et, lv ? "R6/R7" : "R4", {ph, " res_targets"}, res_targets, et);
      chk(res_no_snoop == (lv && et == '0), lv ? "R5" : "R4", {ph, " res_no_snoop"},
          res_no_snoop, (lv && et == '0));
      chk(res_dirty == ed, "R9", {ph, " res_dirty"}, res_dirty, ed);
   endtask

   task automatic look(input int lc, input logic [31:0] la, input string ph);
      cyc(1, lc, la, 0, 0, 0, 0, 0, 0, 0, 0, 0, ph);
   endtask

   initial begin
      for (int c = 0; c < NC; c++)
         for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
               mv[c][s][w] = 0; md[c][s][w] = 0; mt[c][s][w] = 0;
            end
      repeat (3) @(negedge clk);
      // R1: outputs held low in reset.
      chk(res_valid == 0 && res_no_snoop == 0 && res_targets == 0 && res_dirty == 0,
          "R1", "reset outputs", {res_valid, res_no_snoop, res_targets, res_dirty}, 0);
      rst_n = 1'b1;
      // R1: empty filter always reports no snoop.
      for (int s = 0; s < NS; s++) look(s % NC, mk(s*7, s, s), "R1 empty");

      // R3: fill every entry of every core.
      for (int c = 0; c < NC; c++)
         for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
               cyc(0, 0, 0, 1, c, w, mk(pt(c, s, w), s, c*100 + w), (c + s + w) % 2,
                   0, 0, 0, 0, "R3 fill");

      // R6 R7 R9 R12: probe every stored tag from every requester, upper bits altered.
      for (int r = 0; r < NC; r++)
         for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < NC; c++)
               for (int w = 0; w < NW; w++)
                  look(r, mk(pt(c, s, w), s, 9999 - r*13 - w), "R6 probe");
            look(r, mk(255, s, 7), "R5 miss");
            look(r, mk(pt(c_other(r), (s + 1) % NS, 0), s, 1), "R12 other set");
         end

      // R8: drop odd ways of cores 1 and 2, then re-probe.
      for (int s = 0; s < NS; s++)
         for (int w = 1; w < NW; w += 2) begin
            cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, s, w, "R8 inv");
            cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, s, w, "R8 inv");
         end
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++)
               look(0, mk(pt(c, s, w), s, 3), "R8 probe");

      // R10: lookup alongside a fill of the same set sees old contents, next lookup sees new.
      cyc(1, 0, mk(200, 3, 5), 1, 1, 1, mk(200, 3, 6), 1, 0, 0, 0, 0, "R10 same cycle");
      look(0, mk(200, 3, 5), "R10 after");
      cyc(1, 0, mk(200, 3, 5), 0, 0, 0, 0, 0, 1, 1, 3, 1, "R10 inv same cycle");
      look(0, mk(200, 3, 5), "R10 inv after");

      // R11: fill and invalidate of one entry in the same cycle; fill stays.
      cyc(0, 0, 0, 1, 2, 3, mk(201, 5, 0), 0, 1, 2, 5, 3, "R11 both");
      look(1, mk(201, 5, 9), "R11 after");

      // Mixed traffic with a small tag pool for frequent matches.
      for (int i = 0; i < 4000; i++) begin
         int u;
         u = $urandom;
         cyc(u[0], u[2:1], mk(u[4:3], u[8:5], u[31:20]),
             u[9], u[11:10], u[13:12], mk(u[15:14], u[19:16], u[30:24]), u[23],
             u[22] & u[21], u[20:19], u[8:5], u[17:16], "R10 mixed");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic int c_other(input int r);
      return (r + 1) % NC;
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule